// File: doc/BRIEF.md
# Pipelined Synchronous Burst SRAM

This block is a single-clock static RAM. Every input is registered, reads are pipelined and a deselect takes effect after one cycle. A word is 36 bits wide, held as four 9-bit byte lanes, and the depth is set by an address-width parameter. The block samples all of its inputs on the rising clock edge. The access itself then happens on the following edge. A read word therefore reaches the output one clock after the request was captured.

A burst of up to four beats begins on either of two start strobes. The processor-side strobe always reads. The cache-side strobe reads or writes according to the write controls. Each later beat is requested with the advance input. A 2-bit counter produces the low two address bits for these beats, in either linear or interleaved order. The order is picked per cycle by the order input. Writes can cover selected byte lanes, or all four lanes when the write-all input is raised. When no read word is being delivered, the output is flagged invalid and its data is held at zero.

Top module: `burst_sram`

## Requirements
- R1: While `rst_n` is low, and after it rises until the first read completes, `rvalid` is 0 and `rdata` is 0.
- R2: With `chip_en` high, a high `start_cpu` or `start_cache` stores `addr` as the burst base and accesses that address.
- R3: A start with `start_cpu` high is a read, whatever the write controls and `start_cache` say. A start with only `start_cache` high is a write when `wr_all` is high, or when `wr_byte_en` is high together with at least one `wr_lane` bit. Otherwise it is a read.
- R4: With `chip_en` high and no start strobe, a high `advance` during an open burst performs one beat, using the same write-control decode as R3. If `advance` is low, or no burst is open, there is no access and `rvalid` stays 0.
- R5: With `order_ilv` = 0, beat k (k = 1, 2, 3, ...) uses address bits [1:0] = (base[1:0] + k) mod 4.
- R6: With `order_ilv` = 1, beat k uses address bits [1:0] = base[1:0] XOR (k mod 4).
- R7: Bits above bit 1 keep the base value for the whole burst. The fourth advance wraps back to the base address.
- R8: A lane write changes only lane i, that is `wdata` bits [9i+8:9i], for each set bit i of `wr_lane`. All other lanes keep their contents.
- R9: `wr_all` writes all four lanes even when `wr_byte_en` and `wr_lane` are all zero. A write does not raise `rvalid`.
- R10: Inputs are captured on clock edge N. For a read, `rvalid` is 1 and `rdata` holds the addressed word right after edge N+1. That word includes any write captured on edge N-1 or earlier.
- R11: `chip_en` low at edge N gives `rvalid` = 0 after edge N+1. It also closes the open burst, so a later advance without a start does nothing.
- R12: Whenever `rvalid` is 0, `rdata` is all zeros.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| chip_en | input | 1 | Chip enable, active high |
| start_cpu | input | 1 | Read-only burst start strobe |
| start_cache | input | 1 | Read/write burst start strobe |
| advance | input | 1 | Request next burst beat |
| wr_all | input | 1 | Write all four lanes |
| wr_byte_en | input | 1 | Enable for per-lane writes |
| wr_lane | input | 4 | Per-lane write selects |
| order_ilv | input | 1 | 0 = linear order, 1 = interleaved order |
| addr | input | ADDR_W | Word address |
| wdata | input | 36 | Write data, four 9-bit lanes |
| rdata | output | 36 | Read data, zero when not valid |
| rvalid | output | 1 | Read data valid |

## Verification
The assertions check, on every cycle and at the ports, the output timing that follows from the control pattern captured two edges earlier. A processor start must yield valid data. A deselect, an idle cycle or a write-all start must yield none. Invalid output must carry zero data. Only the bench scenarios can show the data values. These include the linear and interleaved address sequences from every start offset, the wrap after the fourth beat, the lane isolation of byte writes and the write-all override. The bench checks them against its own reference array.

// File: rtl/bsram_pkg.sv
package bsram_pkg;
    localparam int LANES  = 4;
    localparam int LANE_W = 9;
    localparam int WORD_W = LANES * LANE_W;
    localparam int CNT_W  = 2;

    // Registered control inputs of one cycle.
    typedef struct packed {
        logic             ce;
        logic             st_cpu;
        logic             st_cache;
        logic             adv;
        logic             wr_all;
        logic             wr_byte_en;
        logic [LANES-1:0] wr_lane;
        logic             ilv;
    } ctl_t;
endpackage

// File: rtl/bsram_inreg.sv
// Input capture stage: registers every synchronous input on the rising edge.
// Assumes: a synchronous active-low reset; the control word is cleared in reset.
module bsram_inreg
    import bsram_pkg::*;
#(
    parameter int ADDR_W = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  ctl_t              ctl_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [WORD_W-1:0] wdata_i,
    output ctl_t              ctl_q,
    output logic [ADDR_W-1:0] addr_q,
    output logic [WORD_W-1:0] wdata_q
);
    // Capture address, data and control once per clock.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctl_q   <= '0;
            addr_q  <= '0;
            wdata_q <= '0;
        end else begin
            ctl_q   <= ctl_i;
            addr_q  <= addr_i;
            wdata_q <= wdata_i;
        end
    end
endmodule

// File: rtl/bsram_burst.sv
// Burst sequencer: decodes the captured controls into one access per cycle.
// It keeps the burst base and the 2-bit beat counter.
// Assumes ADDR_W >= 3; the order select is taken from the current cycle.
module bsram_burst
    import bsram_pkg::*;
#(
    parameter int ADDR_W = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  ctl_t              ctl_q,
    input  logic [ADDR_W-1:0] addr_q,
    output logic              acc_vld,
    output logic              acc_wr,
    output logic [ADDR_W-1:0] acc_addr,
    output logic [LANES-1:0]  acc_mask
);
    logic              active;
    logic [ADDR_W-1:0] base;
    logic [CNT_W-1:0]  cnt;
    logic [CNT_W-1:0]  cnt_nxt;
    logic [CNT_W-1:0]  low_nxt;
    logic              start;
    logic              step;
    logic              wr_req;

    // Decode the start, the step and the write request; form the access address.
    always_comb begin
        start    = ctl_q.ce && (ctl_q.st_cpu || ctl_q.st_cache);
        step     = ctl_q.ce && !start && ctl_q.adv && active;
        wr_req   = ctl_q.wr_all || (ctl_q.wr_byte_en && (|ctl_q.wr_lane));
        acc_mask = ctl_q.wr_all ? '1 : (ctl_q.wr_byte_en ? ctl_q.wr_lane : '0);
        cnt_nxt  = cnt + 1'b1;
        low_nxt  = ctl_q.ilv ? (base[CNT_W-1:0] ^ cnt_nxt)
                             : (base[CNT_W-1:0] + cnt_nxt);
        acc_vld  = start || step;
        acc_wr   = 1'b0;
        acc_addr = addr_q;
        if (start) begin
            acc_wr   = !ctl_q.st_cpu && wr_req;
            acc_addr = addr_q;
        end else if (step) begin
            acc_wr   = wr_req;
            acc_addr = {base[ADDR_W-1:CNT_W], low_nxt};
        end
    end

    // Track the open burst: load the base on a start, count on a step, close on deselect.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            active <= 1'b0;
            base   <= '0;
            cnt    <= '0;
        end else if (!ctl_q.ce) begin
            active <= 1'b0;
        end else if (start) begin
            active <= 1'b1;
            base   <= addr_q;
            cnt    <= '0;
        end else if (step) begin
            cnt    <= cnt_nxt;
        end
    end
endmodule

// File: rtl/bsram_array.sv
// Storage array: one memory per byte lane, so each lane is written on its own.
// The read is combinational and the output stage registers it.
// Assumes the contents are not reset.
module bsram_array
    import bsram_pkg::*;
#(
    parameter int ADDR_W = 6
) (
    input  logic              clk,
    input  logic              we,
    input  logic [LANES-1:0]  mask,
    input  logic [ADDR_W-1:0] addr,
    input  logic [WORD_W-1:0] wdata,
    output logic [WORD_W-1:0] rword
);
    localparam int DEPTH = 1 << ADDR_W;

    for (genvar l = 0; l < LANES; l++) begin : g_lane
        logic [LANE_W-1:0] mem [DEPTH];

        // Write this lane when it is selected.
        always_ff @(posedge clk) begin
            if (we && mask[l]) begin
                mem[addr] <= wdata[l*LANE_W +: LANE_W];
            end
        end

        assign rword[l*LANE_W +: LANE_W] = mem[addr];
    end
endmodule

// File: rtl/bsram_outreg.sv
// Output pipeline register: holds the read word for one cycle and forces zero when idle.
// Assumes a synchronous active-low reset.
module bsram_outreg
    import bsram_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rd_en,
    input  logic [WORD_W-1:0] rword,
    output logic [WORD_W-1:0] rdata,
    output logic              rvalid
);
    // Register the read result, or clear the output when there is no read.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rdata  <= '0;
            rvalid <= 1'b0;
        end else if (rd_en) begin
            rdata  <= rword;
            rvalid <= 1'b1;
        end else begin
            rdata  <= '0;
            rvalid <= 1'b0;
        end
    end
endmodule

// File: rtl/burst_sram.sv
// Top level of the pipelined burst SRAM: input stage, burst sequencer, lane array and output register.
// Assumes one clock and a synchronous active-low reset.
module burst_sram
    import bsram_pkg::*;
#(
    parameter int ADDR_W = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              chip_en,
    input  logic              start_cpu,
    input  logic              start_cache,
    input  logic              advance,
    input  logic              wr_all,
    input  logic              wr_byte_en,
    input  logic [3:0]        wr_lane,
    input  logic              order_ilv,
    input  logic [ADDR_W-1:0] addr,
    input  logic [35:0]       wdata,
    output logic [35:0]       rdata,
    output logic              rvalid
);
    ctl_t              ctl_d;
    ctl_t              ctl_q;
    logic [ADDR_W-1:0] addr_q;
    logic [WORD_W-1:0] wdata_q;
    logic              acc_vld;
    logic              acc_wr;
    logic [ADDR_W-1:0] acc_addr;
    logic [LANES-1:0]  acc_mask;
    logic [WORD_W-1:0] rword;

    // Pack the control pins into one word for the input stage.
    always_comb begin
        ctl_d.ce         = chip_en;
        ctl_d.st_cpu     = start_cpu;
        ctl_d.st_cache   = start_cache;
        ctl_d.adv        = advance;
        ctl_d.wr_all     = wr_all;
        ctl_d.wr_byte_en = wr_byte_en;
        ctl_d.wr_lane    = wr_lane;
        ctl_d.ilv        = order_ilv;
    end

    bsram_inreg #(.ADDR_W(ADDR_W)) u_inreg (
        .clk     (clk),
        .rst_n   (rst_n),
        .ctl_i   (ctl_d),
        .addr_i  (addr),
        .wdata_i (wdata),
        .ctl_q   (ctl_q),
        .addr_q  (addr_q),
        .wdata_q (wdata_q)
    );

    bsram_burst #(.ADDR_W(ADDR_W)) u_burst (
        .clk      (clk),
        .rst_n    (rst_n),
        .ctl_q    (ctl_q),
        .addr_q   (addr_q),
        .acc_vld  (acc_vld),
        .acc_wr   (acc_wr),
        .acc_addr (acc_addr),
        .acc_mask (acc_mask)
    );

    bsram_array #(.ADDR_W(ADDR_W)) u_array (
        .clk   (clk),
        .we    (acc_vld && acc_wr),
        .mask  (acc_mask),
        .addr  (acc_addr),
        .wdata (wdata_q),
        .rword (rword)
    );

    bsram_outreg u_outreg (
        .clk    (clk),
        .rst_n  (rst_n),
        .rd_en  (acc_vld && !acc_wr),
        .rword  (rword),
        .rdata  (rdata),
        .rvalid (rvalid)
    );
endmodule

// File: rtl/bsram_chk.sv
// Port-level checker for burst_sram. It relates the inputs captured two edges back to the output now.
module bsram_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        chip_en,
    input logic        start_cpu,
    input logic        start_cache,
    input logic        advance,
    input logic        wr_all,
    input logic [35:0] rdata,
    input logic        rvalid
);
    logic [1:0] up;

    // Count two clean cycles since reset, so that $past depth 2 looks only at post-reset inputs.
    always_ff @(posedge clk) begin
        if (!rst_n) up <= 2'b00;
        else        up <= {up[0], 1'b1};
    end

    AST_DESELECT_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (up[1] && $past(!chip_en, 2)) |-> !rvalid); // R11

    AST_CPU_START_READS: assert property (@(posedge clk) disable iff (!rst_n)
        (up[1] && $past(chip_en && start_cpu, 2)) |-> rvalid); // R3

    AST_IDLE_NO_ACCESS: assert property (@(posedge clk) disable iff (!rst_n)
        (up[1] && $past(chip_en && !start_cpu && !start_cache && !advance, 2)) |-> !rvalid); // R4

    AST_WRITE_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
        (up[1] && $past(chip_en && !start_cpu && start_cache && wr_all, 2)) |-> !rvalid); // R9

    AST_INVALID_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        !rvalid |-> (rdata == 36'd0)); // R12
endmodule

bind burst_sram bsram_chk u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .chip_en     (chip_en),
    .start_cpu   (start_cpu),
    .start_cache (start_cache),
    .advance     (advance),
    .wr_all      (wr_all),
    .rdata       (rdata),
    .rvalid      (rvalid)
);

// File: tb/burst_sram_tb_top.sv
module burst_sram_tb_top;
    localparam int AW = 6;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          chip_en = 1'b0, start_cpu = 1'b0, start_cache = 1'b0, advance = 1'b0;
    logic          wr_all = 1'b0, wr_byte_en = 1'b0, order_ilv = 1'b0;
    logic [3:0]    wr_lane = 4'd0;
    logic [AW-1:0] addr = '0;
    logic [35:0]   wdata = '0;
    logic [35:0]   rdata;
    logic          rvalid;

    int checks = 0;
    int fails  = 0;

    always #10 clk = ~clk;

    burst_sram #(.ADDR_W(AW)) dut_i (
        .clk(clk), .rst_n(rst_n), .chip_en(chip_en), .start_cpu(start_cpu),
        .start_cache(start_cache), .advance(advance), .wr_all(wr_all),
        .wr_byte_en(wr_byte_en), .wr_lane(wr_lane), .order_ilv(order_ilv),
        .addr(addr), .wdata(wdata), .rdata(rdata), .rvalid(rvalid)
    );

    // Stimulus vector: ce, cpu, cache, adv, all, byte_en, lanes, ilv, addr, data, expected valid.
    typedef struct packed {
        logic        ce, sp, sc, adv, ga, be;
        logic [3:0]  bl;
        logic        il;
        logic [5:0]  ad;
        logic [35:0] wd;
        logic        xv;
    } vec_t;

    localparam int NV = 12;
    localparam vec_t TAB [NV] = '{
        '{1'b1,1'b0,1'b1,1'b0,1'b1,1'b0,4'h0,1'b0,6'd8, 36'h1_2345_6789,1'b0}, // write all
        '{1'b1,1'b0,1'b1,1'b0,1'b0,1'b1,4'h5,1'b0,6'd8, 36'hA_BCDE_F012,1'b0}, // lanes 0,2
        '{1'b1,1'b1,1'b0,1'b0,1'b1,1'b0,4'h0,1'b0,6'd8, 36'h0,          1'b1}, // cpu start reads
        '{1'b1,1'b0,1'b1,1'b0,1'b0,1'b0,4'hF,1'b0,6'd8, 36'h0,          1'b1}, // cache read
        '{1'b1,1'b0,1'b0,1'b1,1'b0,1'b0,4'h0,1'b0,6'd0, 36'h0,          1'b1}, // beat to 9
        '{1'b1,1'b0,1'b0,1'b1,1'b0,1'b1,4'h8,1'b0,6'd0, 36'h5_5555_5555,1'b0}, // write 10
        '{1'b1,1'b0,1'b0,1'b1,1'b0,1'b0,4'h0,1'b0,6'd0, 36'h0,          1'b1}, // beat to 11
        '{1'b1,1'b0,1'b0,1'b0,1'b0,1'b0,4'h0,1'b0,6'd0, 36'h0,          1'b0}, // idle
        '{1'b1,1'b0,1'b0,1'b1,1'b0,1'b0,4'h0,1'b0,6'd0, 36'h0,          1'b1}, // wrap to 8
        '{1'b0,1'b1,1'b0,1'b0,1'b0,1'b0,4'h0,1'b0,6'd9, 36'h0,          1'b0}, // deselect
        '{1'b1,1'b0,1'b0,1'b1,1'b0,1'b0,4'h0,1'b0,6'd0, 36'h0,          1'b0}, // burst closed
        '{1'b1,1'b1,1'b1,1'b0,1'b1,1'b0,4'h0,1'b0,6'd9, 36'h0,          1'b1}  // both strobes
    };

    // Reference model state.
    logic [35:0] bm_mem [64];
    logic        m_act = 1'b0;
    logic [5:0]  m_base = '0;
    logic [1:0]  m_cnt = '0;

    // Two-deep pipeline of pending expectations.
    logic        p1_on = 1'b0, p2_on = 1'b0;
    logic        p1_v, p2_v;
    logic [35:0] p1_d, p2_d;
    string       p1_t, p2_t;

    task automatic check(input string tag, input logic ev, input logic [35:0] ed);
        logic [35:0] exp_d;
        exp_d = ev ? ed : 36'd0;
        checks++;
        if (rvalid !== ev || rdata !== exp_d) begin
            fails++;
            $display("FAIL %s: rvalid=%0b rdata=%h expected rvalid=%0b rdata=%h",
                     tag, rvalid, rdata, ev, exp_d);
        end
    endtask

    // Apply one cycle of stimulus; check the cycle driven two applies earlier.
    task automatic apply(input vec_t v, input int xv, input string tag);
        logic        st, sp_, wr, ev;
        logic [1:0]  c, lo;
        logic [5:0]  a;
        logic [3:0]  mk;
        logic [35:0] ed;
        @(negedge clk);
        if (p2_on) check(p2_t, p2_v, p2_d);
        p2_on = p1_on; p2_v = p1_v; p2_d = p1_d; p2_t = p1_t;
        chip_en = v.ce; start_cpu = v.sp; start_cache = v.sc; advance = v.adv;
        wr_all = v.ga; wr_byte_en = v.be; wr_lane = v.bl; order_ilv = v.il;
        addr = v.ad; wdata = v.wd;
        // Reference behaviour taken from the requirements.
        st  = v.ce && (v.sp || v.sc);
        sp_ = v.ce && !st && v.adv && m_act;
        mk  = v.ga ? 4'hF : (v.be ? v.bl : 4'h0);
        wr  = (mk != 4'h0);
        ev = 1'b0; ed = '0; a = v.ad; c = m_cnt;
        if (st) begin
            a = v.ad; wr = wr && !v.sp; ev = !wr;
        end else if (sp_) begin
            c  = m_cnt + 2'd1;
            lo = v.il ? (m_base[1:0] ^ c) : (m_base[1:0] + c);   // R5 R6
            a  = {m_base[5:2], lo}; ev = !wr;
        end
        if ((st || sp_) && wr) begin
            for (int l = 0; l < 4; l++)
                if (mk[l]) bm_mem[a][l*9 +: 9] = v.wd[l*9 +: 9];
        end
        if (ev) ed = bm_mem[a];
        if (!v.ce) m_act = 1'b0;
        else if (st) begin m_act = 1'b1; m_base = v.ad; m_cnt = 2'd0; end
        else if (sp_) m_cnt = c;
        p1_on = 1'b1; p1_v = (xv >= 0) ? xv[0] : ev; p1_d = ed; p1_t = tag;
    endtask

    function automatic vec_t mk(input logic ce, sp, sc, adv, ga, be, input logic [3:0] bl,
                                input logic il, input logic [5:0] ad, input logic [35:0] wd);
        vec_t v;
        v = '{ce, sp, sc, adv, ga, be, bl, il, ad, wd, 1'b0};
        return v;
    endfunction

    function automatic string tag_of(input vec_t v);
        if (!v.ce)         return "R11";
        if (v.sp)          return "R3";
        if (v.sc)          return "R2";
        if (!v.adv)        return "R4";
        if (v.be || v.ga)  return "R8";
        return "R10";
    endfunction

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: run did not finish, expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin : main
        for (int i = 0; i < 64; i++) bm_mem[i] = '0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        check("R1", 1'b0, 36'd0);          // output idle during reset
        rst_n = 1'b1;
        @(negedge clk);
        check("R1", 1'b0, 36'd0);          // still idle after release

        // Prefill words 0..15 with write-all starts that carry no lane enables.
        for (int a = 0; a < 16; a++)
            apply(mk(1,0,1,0,1,0,4'h0,0,6'(a), 36'h3_0000_0000 | 36'(a * 36'h1_0203)), -1, "R9");

        // Table walk.
        for (int i = 0; i < NV; i++)
            apply(TAB[i], int'(TAB[i].xv), tag_of(TAB[i]));

        // Bursts from every offset, linear and interleaved, with wrap on the fourth advance.
        for (int il = 0; il < 2; il++) begin
            for (int off = 0; off < 4; off++) begin
                apply(mk(1,1,0,0,0,0,4'h0,1'(il),6'(4 + off),36'h0), 1, "R2");
                for (int k = 1; k <= 4; k++)
                    apply(mk(1,0,0,1,0,0,4'h0,1'(il),6'd0,36'h0), 1,
                          (k == 4) ? "R7" : ((il == 1) ? "R6" : "R5"));
            end
        end

        // Single-lane writes, each followed by a read.
        for (int l = 0; l < 4; l++) begin
            apply(mk(1,0,1,0,0,1,4'(1 << l),0,6'd2,36'h1_FF_FF_FF_FF ^ 36'(l * 36'h1_1111)), 0, "R8");
            apply(mk(1,1,0,0,0,0,4'h0,0,6'd2,36'h0), 1, "R8");
        end

        // A lane select without the byte enable is a read, not a write.
        apply(mk(1,0,1,0,0,0,4'h6,0,6'd3,36'hF_FFFF_FFFF), 1, "R3");
        // Write-all overrides empty lane controls.
        apply(mk(1,0,1,0,1,0,4'h0,0,6'd3,36'h7_6543_210F), 0, "R9");
        apply(mk(1,1,0,0,0,0,4'h0,0,6'd3,36'h0), 1, "R9");

        // Read, then deselect the next cycle: the output drops one cycle later.
        apply(mk(1,1,0,0,0,0,4'h0,0,6'd5,36'h0), 1, "R10");
        apply(mk(0,0,0,0,0,0,4'h0,0,6'd0,36'h0), 0, "R12");
        apply(mk(1,0,0,1,0,0,4'h0,0,6'd0,36'h0), 0, "R11");

        // Flush the pipeline.
        apply(mk(0,0,0,0,0,0,4'h0,0,6'd0,36'h0), 0, "R11");
        apply(mk(0,0,0,0,0,0,4'h0,0,6'd0,36'h0), 0, "R11");
        @(negedge clk);
        if (p2_on) check(p2_t, p2_v, p2_d);
        @(negedge clk);
        if (p1_on) check(p1_t, p1_v, p1_d);

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule